// File: doc/BRIEF.md
# Run-Length Decoder with Look-Back

This block watches a serial NRZ run-length-coded bit stream, taking one sample per channel clock. It measures how long each run of equal samples lasts. It marks each run as a write run or an erase run, and emits one 6-bit strategy index per run. That index selects a laser pulse pattern further down the chain. Short write runs get separate indices depending on the length of the erase run before them, so the pulse pattern can pre-compensate for thermal effects left by that erase. A run longer than the longest legal length sends the decoder to a read state.

A forced-erase control overrides the data stream and reports a continuous erase. A polarity-mode control chooses how polarity is decided. In edge-only mode, polarity simply alternates from run to run. In level mode, the sampled level decides it: a high run is write and a low run is erase. Every result leaves the block after the same fixed number of channel clocks, whatever the run lengths, so the write pulses can be placed on the medium with a known offset from the data.

Top module: `rld_decoder`

## Requirements
- R1: An erase run of length L (1 to 15 samples) is reported with `idx` = L and `status` = 1 (erase). Runs of 15 samples or fewer are all accepted as valid.
- R2: When the 16th equal sample in a row arrives, the index 0 is reported once, with `status` = 0 (read) and `rd_wr` = 1. No index is emitted when that long run later ends.
- R3: In edge-only mode (`level_mode` = 0), consecutive runs alternate between write and erase. The first run that starts after reset, after a read, or after a forced erase is a write run.
- R4: A write run of length L reports `status` = 2 (write). For L from 1 to 5, `idx` = 16 + 6·(L−1) + s. Here s = P−1 when the preceding erase run had length P between 1 and 5, and s = 5 otherwise. For L from 6 to 15, `idx` = 40 + L.
- R5: A run that has no preceding run, because it is the first after reset, read or forced erase, uses the "other" look-back selector s = 5.
- R6: In level mode (`level_mode` = 1), a run of high samples is a write run and a run of low samples is an erase run. This also holds for the first run after a read.
- R7: While `force_erase` is high, the data input is ignored, the run in progress is dropped, no index is emitted, and the outputs show `status` = 1 with `rd_wr` = 0. After release, the outputs show `status` = 0 with `rd_wr` = 1. A new run then begins only at the next change of the input level.
- R8: Every output update appears exactly LATENCY (default 28) clock edges after the edge that samples its cause. For a run, the cause is the first sample of the following run. For a read, it is the 16th equal sample. For forced erase, it is the first sample with `force_erase` high, or the first sample with it low.
- R9: After synchronous reset, `idx_valid` = 0, `idx` = 0, `status` = 0 and `rd_wr` = 1.
- R10: `idx_valid` is high for exactly one clock per reported run or read event, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, one data sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | NRZ run-length-coded data sample |
| force_erase | input | 1 | Forced-erase override, active high |
| level_mode | input | 1 | 0: polarity alternates per run; 1: the sampled level gives the polarity |
| idx | output | IDX_W | Strategy index of the last reported event |
| idx_valid | output | 1 | One-clock strobe that marks a new index |
| status | output | 2 | 0 read, 1 erase, 2 write |
| rd_wr | output | 1 | High in read state, low while writing or erasing |

## Verification
The assertions assume that `din` and `force_erase` are synchronous to `clk`. They also assume that `level_mode` is static configuration, changed only while the decoder is in reset. With that assumption, a run that starts while the decoder is idle takes its polarity from one stable setting. The stimulus builds the stream from whole runs that always change level at each boundary. It sets `level_mode` only while `rst` is held. It drains pending results with a final over-long run before each new reset, so no expected event is ever left stranded across a reset.

// File: rtl/rld_pkg.sv
package rld_pkg;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2
  } rld_status_e;

endpackage

// File: rtl/rld_run_tracker.sv
module rld_run_tracker #(
  parameter int MAX_RUN = 15,
  parameter int CNT_W   = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             force_erase,
  input  logic             level_mode,
  output logic             ev_run,
  output logic             ev_read,
  output logic             ev_release,
  output logic [CNT_W-1:0] run_len,
  output logic             run_write,
  output logic [CNT_W-1:0] prev_len
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_RUN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic             din_last;
  logic             force_last;
  logic             active;
  logic             wr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hist;
  logic             trans;

  assign trans      = din != din_last;
  assign ev_run     = !force_erase && active && trans;
  assign ev_read    = !force_erase && active && !trans && (cnt == MAX_C);
  assign ev_release = force_last && !force_erase;
  assign run_len    = cnt;
  assign run_write  = wr;
  assign prev_len   = hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_last   <= 1'b0;
      force_last <= 1'b0;
      active     <= 1'b0;
      wr         <= 1'b0;
      cnt        <= '0;
      hist       <= '0;
    end else begin
      din_last   <= din;
      force_last <= force_erase;
      if (force_erase) begin
        active <= 1'b0;
        cnt    <= '0;
        hist   <= '0;
      end else if (active) begin
        if (trans) begin
          hist <= cnt;
          cnt  <= ONE_C;
          wr   <= level_mode ? din : ~wr;
        end else if (cnt == MAX_C) begin
          active <= 1'b0;
          cnt    <= '0;
          hist   <= '0;
        end else begin
          cnt <= cnt + ONE_C;
        end
      end else if (trans) begin
        active <= 1'b1;
        cnt    <= ONE_C;
        hist   <= '0;
        wr     <= level_mode ? din : 1'b1;
      end
    end
  end

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0) && (cnt <= MAX_C));

  // R2
  read_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ev_read |=> !active);

  // R3
  alternate_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_run && !level_mode) |=> (wr != $past(wr)));

  // R6
  level_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (!force_erase && trans && level_mode) |=> (wr == $past(din)));

  // R7
  force_idle_chk: assert property (@(posedge clk) disable iff (rst)
    force_erase |=> !active);

endmodule

// File: rtl/rld_index_map.sv
module rld_index_map #(
  parameter int MAX_RUN  = 15,
  parameter int LOOKBACK = 5,
  parameter int CNT_W    = $clog2(MAX_RUN + 1),
  parameter int IDX_W    = 6
) (
  input  logic             is_read,
  input  logic             run_write,
  input  logic [CNT_W-1:0] run_len,
  input  logic [CNT_W-1:0] prev_len,
  output logic [IDX_W-1:0] idx
);

  localparam int W_BASE    = MAX_RUN + 1;
  localparam int SEL_N     = LOOKBACK + 1;
  localparam int LONG_BASE = W_BASE + LOOKBACK * SEL_N;

  int len_i;
  int prev_i;
  int sel_i;
  int idx_i;

  always_comb begin
    len_i  = int'(run_len);
    prev_i = int'(prev_len);
    sel_i  = ((prev_i >= 1) && (prev_i <= LOOKBACK)) ? (prev_i - 1) : LOOKBACK;
    if (is_read) begin
      idx_i = 0;
    end else if (!run_write) begin
      idx_i = len_i;
    end else if (len_i <= LOOKBACK) begin
      idx_i = W_BASE + (len_i - 1) * SEL_N + sel_i;
    end else begin
      idx_i = LONG_BASE + len_i - (LOOKBACK + 1);
    end
    idx = IDX_W'(idx_i);
  end

endmodule

// File: rtl/rld_delay_line.sv
module rld_delay_line #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/rld_decoder.sv
module rld_decoder #(
  parameter int MAX_RUN  = 15,
  parameter int LOOKBACK = 5,
  parameter int LATENCY  = 28,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             force_erase,
  input  logic             level_mode,
  output logic [IDX_W-1:0] idx,
  output logic             idx_valid,
  output logic [1:0]       status,
  output logic             rd_wr
);

  import rld_pkg::*;

  localparam int CNT_W = $clog2(MAX_RUN + 1);
  localparam int ENT_W = IDX_W + 5;

  logic             ev_run;
  logic             ev_read;
  logic             ev_release;
  logic [CNT_W-1:0] run_len;
  logic             run_write;
  logic [CNT_W-1:0] prev_len;
  logic [IDX_W-1:0] map_idx;

  logic             e_upd;
  logic             e_vld;
  logic             e_rdwr;
  rld_status_e      e_st;
  logic [ENT_W-1:0] ent_in;
  logic [ENT_W-1:0] ent_out;

  rld_run_tracker #(
    .MAX_RUN (MAX_RUN),
    .CNT_W   (CNT_W)
  ) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .force_erase(force_erase),
    .level_mode (level_mode),
    .ev_run     (ev_run),
    .ev_read    (ev_read),
    .ev_release (ev_release),
    .run_len    (run_len),
    .run_write  (run_write),
    .prev_len   (prev_len)
  );

  rld_index_map #(
    .MAX_RUN (MAX_RUN),
    .LOOKBACK(LOOKBACK),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) u_map (
    .is_read  (ev_read),
    .run_write(run_write),
    .run_len  (run_len),
    .prev_len (prev_len),
    .idx      (map_idx)
  );

  always_comb begin
    e_upd  = 1'b0;
    e_vld  = 1'b0;
    e_rdwr = 1'b0;
    e_st   = ST_READ;
    if (force_erase) begin
      e_upd = 1'b1;
      e_st  = ST_ERASE;
    end else if (ev_release) begin
      e_upd  = 1'b1;
      e_rdwr = 1'b1;
    end else if (ev_read) begin
      e_upd  = 1'b1;
      e_vld  = 1'b1;
      e_rdwr = 1'b1;
    end else if (ev_run) begin
      e_upd = 1'b1;
      e_vld = 1'b1;
      e_st  = run_write ? ST_WRITE : ST_ERASE;
    end
  end

  assign ent_in = {e_upd, e_vld, e_rdwr, e_st, map_idx};

  rld_delay_line #(
    .WIDTH(ENT_W),
    .DEPTH(LATENCY)
  ) u_delay (
    .clk(clk),
    .rst(rst),
    .d  (ent_in),
    .q  (ent_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      idx_valid <= 1'b0;
      status    <= ST_READ;
      rd_wr     <= 1'b1;
    end else begin
      idx_valid <= ent_out[IDX_W+3];
      if (ent_out[IDX_W+4]) begin
        status <= ent_out[IDX_W+1:IDX_W];
        rd_wr  <= ent_out[IDX_W+2];
      end
      if (ent_out[IDX_W+3]) idx <= ent_out[IDX_W-1:0];
    end
  end

  // R2
  read_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_valid && status == ST_READ) |-> (idx == '0) && rd_wr);

  // R1
  erase_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_valid && status == ST_ERASE) |-> (int'(idx) >= 1) && (int'(idx) <= MAX_RUN) && !rd_wr);

  // R4
  write_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_valid && status == ST_WRITE) |-> (int'(idx) > MAX_RUN) && !rd_wr);

  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    status != 2'd3);

endmodule

// File: tb/rld_decoder_test.sv
module rld_decoder_test;

  localparam int LAT = 28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic       force_erase = 1'b0;
  logic       level_mode = 1'b0;
  logic [5:0] idx;
  logic       idx_valid;
  logic [1:0] status;
  logic       rd_wr;

  always #5 clk = ~clk;

  rld_decoder uut (
    .clk(clk), .rst(rst), .din(din), .force_erase(force_erase),
    .level_mode(level_mode), .idx(idx), .idx_valid(idx_valid),
    .status(status), .rd_wr(rd_wr)
  );

  int edges = 0;
  always @(posedge clk) edges <= edges + 1;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  int    ev_cyc[$];
  int    ev_idx[$];
  int    ev_st[$];
  string ev_req[$];
  int    sc_cyc[$];
  int    sc_st[$];
  int    sc_rw[$];

  bit    last_lvl;
  bit    pend_v;
  int    pend_len;
  bit    pend_wr;
  int    pend_hist;

  function automatic int exp_write(int len, int prev);
    int s;
    s = (prev >= 1 && prev <= 5) ? prev - 1 : 5;
    if (len <= 5) return 16 + 6 * (len - 1) + s;
    return 40 + len;
  endfunction

  function automatic string mode_tag();
    return level_mode ? "R6" : "R3";
  endfunction

  // monitor: outputs sampled at the falling edge after edge number "edges"
  always @(negedge clk) begin
    if (!rst) begin
      if (ev_cyc.size() > 0 && ev_cyc[0] == edges) begin
        n_chk++;
        if (idx_valid !== 1'b1 || idx !== 6'(ev_idx[0]) || status !== 2'(ev_st[0]) ||
            rd_wr !== (ev_st[0] == 0)) begin
          n_fail++;
          $display("FAIL %s R8 edge %0d: valid=%0b idx=%0d st=%0d rw=%0b expected valid=1 idx=%0d st=%0d rw=%0b",
                   ev_req[0], edges, idx_valid, idx, status, rd_wr, ev_idx[0], ev_st[0], ev_st[0] == 0);
        end
        void'(ev_cyc.pop_front()); void'(ev_idx.pop_front());
        void'(ev_st.pop_front());  void'(ev_req.pop_front());
      end else if (idx_valid === 1'b1) begin
        n_chk++;
        n_fail++;
        $display("FAIL R10 edge %0d: unexpected strobe idx=%0d st=%0d, expected no strobe",
                 edges, idx, status);
      end
      while (sc_cyc.size() > 0 && sc_cyc[0] == edges) begin
        n_chk++;
        if (status !== 2'(sc_st[0]) || rd_wr !== sc_rw[0][0]) begin
          n_fail++;
          $display("FAIL R7 edge %0d: st=%0d rw=%0b expected st=%0d rw=%0d",
                   edges, status, rd_wr, sc_st[0], sc_rw[0]);
        end
        void'(sc_cyc.pop_front()); void'(sc_st.pop_front()); void'(sc_rw.pop_front());
      end
    end
  end

  task automatic push_ev(int cyc, int ix, int st, string req);
    ev_cyc.push_back(cyc); ev_idx.push_back(ix);
    ev_st.push_back(st);   ev_req.push_back(req);
  endtask

  // send one whole run of level v and length len
  task automatic run(bit v, int len);
    int  t0;
    bit  wr;
    int  hist;
    string req;
    @(negedge clk);
    din = v;
    t0 = edges + 1;
    if (pend_v) begin
      if (pend_wr) begin
        req = (pend_hist == 0) ? "R5" : "R4";
        push_ev(t0 + LAT, exp_write(pend_len, pend_hist), 2, {req, "/", mode_tag()});
      end else begin
        push_ev(t0 + LAT, pend_len, 1, {"R1/", mode_tag()});
      end
      wr = !pend_wr;
      hist = pend_len;
    end else begin
      wr = level_mode ? v : 1'b1;
      hist = 0;
    end
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      din = v;
    end
    if (len >= 16) begin
      push_ev(t0 + 15 + LAT, 0, 0, "R2");
      pend_v = 0;
    end else begin
      pend_v = 1; pend_len = len; pend_wr = wr; pend_hist = hist;
    end
    last_lvl = v;
  endtask

  // R7: hold forced erase for n samples while toggling the data
  task automatic force_phase(int n, bit endlvl);
    int tf;
    int tr;
    @(negedge clk);
    force_erase = 1'b1;
    din = (n == 1) ? endlvl : 1'b0;
    tf = edges + 1;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      din = (i == n - 1) ? endlvl : i[0];
    end
    @(negedge clk);
    force_erase = 1'b0;
    tr = edges + 1;
    sc_cyc.push_back(tf + LAT);     sc_st.push_back(1); sc_rw.push_back(0);
    sc_cyc.push_back(tr + LAT - 1); sc_st.push_back(1); sc_rw.push_back(0);
    sc_cyc.push_back(tr + LAT);     sc_st.push_back(0); sc_rw.push_back(1);
    pend_v = 0;
    last_lvl = endlvl;
  endtask

  task automatic drain();
    run(!last_lvl, 17);
    repeat (LAT + 4) @(negedge clk);
    n_chk++;
    if (ev_cyc.size() != 0 || sc_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL R8 drain: %0d events and %0d status checks left, expected 0",
               ev_cyc.size(), sc_cyc.size());
    end
  endtask

  // R9: reset and check the idle output state
  task automatic do_reset(bit lvl);
    @(negedge clk);
    rst = 1'b1; din = 1'b0; force_erase = 1'b0; level_mode = lvl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pend_v = 0; last_lvl = 1'b0;
    n_chk++;
    if (idx_valid !== 1'b0 || idx !== 6'd0 || status !== 2'd0 || rd_wr !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 reset: valid=%0b idx=%0d st=%0d rw=%0b expected 0 0 0 1",
               idx_valid, idx, status, rd_wr);
    end
  endtask

  initial begin
    // edge-only mode (R3): sweep write lengths against previous erase lengths
    do_reset(1'b0);
    run(1, 3);
    for (int p = 1; p <= 7; p++) begin
      for (int l = 1; l <= 15; l++) begin
        run(0, p);
        run(1, l);
      end
    end
    for (int l = 1; l <= 15; l++) begin
      run(0, l);
      run(1, 2);
    end
    run(0, 20);
    run(1, 2); run(0, 3); run(1, 4); run(0, 2);
    run(1, 18);
    run(0, 4);  // edge-only: write after read, look-back "other"
    run(1, 3); run(0, 5);
    force_phase(6, 1'b1);
    run(0, 3); run(1, 2);
    drain();

    // level mode (R6)
    do_reset(1'b1);
    run(1, 3);
    for (int p = 1; p <= 5; p++) begin
      for (int l = 1; l <= 6; l++) begin
        run(0, p);
        run(1, l);
      end
    end
    run(0, 2);
    run(1, 18);
    run(0, 4);  // level mode: low run after read is erase
    run(1, 3);  // write with previous erase 4
    force_phase(5, 1'b0);
    run(1, 2); run(0, 2);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule